// File: doc/BRIEF.md
# Four-Phase Handshake Transfer Link

This block moves data words from one clock domain to another over a request/acknowledge handshake, with no clock shared between the two ends. A sender state machine takes words from a valid/ready push port. It drives each word onto a data bus and waits a set number of its own clock cycles so the bus can settle. Then it raises a request. A receiver state machine in the other clock domain brings the request into its domain through a flip-flop chain, latches the bus and issues a one-cycle write. It then waits its own hold interval and raises an acknowledge. The request and the acknowledge each return low in turn, and only then can a new transfer begin.

A handshake can carry several words. While the request stays high, the sender toggles a word strobe for each further word, and the receiver answers each strobe by toggling a strobe acknowledge. The bus carries no address. The receiver samples a base address when it detects the request and writes each later word of the same handshake at the next address, wrapping at the top of the address space. The word flagged as last on the push port ends the handshake.

Each end reacts only to the other end's handshake signals, and only after they have passed through its own synchronizer. The setup interval (data to request or strobe), the sender's hold interval (acknowledge to request fall) and the receiver's hold interval (request detection to acknowledge) are parameters counted in local clock cycles.

Top module: `hs_link`

## Requirements
- R1: The handshake runs in four phases in this order: request rises while acknowledge is low, acknowledge rises while request is high, request falls while acknowledge is high, acknowledge falls while request is low.
- R2: After the push port accepts the word flagged last, `in_ready` stays low until the acknowledge has returned low. Whenever `in_ready` is high and the request is low, the acknowledge is low.
- R3: `bus_data` holds its value for at least `TX_SETUP` transmit cycles before the request rises (first word) or before the word strobe toggles (later words).
- R4: The receiver keeps the acknowledge low for at least `RX_HOLD` receive cycles after the write pulse of the first word of a handshake.
- R5: The sender keeps the request high for at least `TX_HOLD` transmit cycles after it sees the acknowledge high, and `bus_data` does not change while the sender waits for an acknowledge or counts its hold interval.
- R6: The first word of a handshake is written at `rx_base`. Each following word of the same handshake is written at the previous address plus one, modulo 2^`AW`.
- R7: `wr_en` is high for exactly one receive cycle per word and is never high on two consecutive receive cycles.
- R8: The receiver acts on the request only after it has passed through at least two receive-domain flip-flops, so the first write of a handshake comes no earlier than two receive-clock samples of a high request.
- R9: While reset is held and right after it is released, request, word strobe, acknowledge, strobe acknowledge and `wr_en` are low and `in_ready` is high.
- R10: Every word accepted on the push port is written exactly once, in acceptance order and with its data unchanged, for single-word and multi-word handshakes alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tx | input | 1 | Sender clock |
| rst_tx | input | 1 | Sender synchronous reset, active high |
| clk_rx | input | 1 | Receiver clock |
| rst_rx | input | 1 | Receiver synchronous reset, active high |
| in_valid | input | 1 | Push port word valid |
| in_ready | output | 1 | Push port ready to accept |
| in_data | input | DW | Push port word |
| in_last | input | 1 | Marks the final word of a handshake |
| rx_base | input | AW | Address of the first word of a handshake, sampled at request detection |
| wr_en | output | 1 | One-cycle write strobe, receive domain |
| wr_addr | output | AW | Write address |
| wr_data | output | DW | Write data |
| bus_req | output | 1 | Handshake request, sender to receiver |
| bus_stb | output | 1 | Word strobe for later words, toggles once per word |
| bus_data | output | DW | Data bus |
| bus_ack | output | 1 | Handshake acknowledge, receiver to sender |
| bus_sack | output | 1 | Strobe acknowledge, toggles once per later word |

## Verification
The bench targets handshakes whose base address sits just below the top of the address space. A design that did not wrap, or that carried the address across handshakes, would write the wrong locations. It drives bursts of alternating all-zero and all-one words, where a receiver sampling the bus too early would capture the previous word. It also sends single-word handshakes back to back, where a sender that reopened its push port before the acknowledge fell would start a request while the acknowledge was still high. It measures every setup and hold spacing at the bus: a counter off by one would raise the request or acknowledge a cycle early, and a missing synchronizer stage would show up as a write too soon after the request.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_SETUP,
        TX_WAIT_ACK,
        TX_WAIT_SACK,
        TX_HOLD,
        TX_NEXT,
        TX_WAIT_LOW
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_HOLD,
        RX_BURST
    } rx_state_e;

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

    logic [DEPTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[DEPTH-2:0], d};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign q = chain_q[DEPTH-1];
endmodule

// File: rtl/hs_tx.sv
module hs_tx
    import hs_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SETUP_CYC   = 3,
    parameter int HOLD_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    output logic          bus_req,
    output logic          bus_stb,
    output logic [DW-1:0] bus_data,
    input  logic          ack_async,
    input  logic          sack_async
);
    localparam int CMAX = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int CW   = $clog2(CMAX + 2);
    localparam int SW   = CW + 1;

    typedef struct packed {
        tx_state_e     st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] data;
        logic          last;
        logic          first;
        logic          req;
        logic          stb;
    } tx_reg_t;

    tx_reg_t r_d, r_q;
    logic    ack_s, sack_s;

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk), .rst(rst), .d(ack_async), .q(ack_s)
    );
    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_sack (
        .clk(clk), .rst(rst), .d(sack_async), .q(sack_s)
    );

    always_comb begin
        r_d      = r_q;
        in_ready = 1'b0;
        unique case (r_q.st)
            TX_IDLE: begin
                in_ready = !ack_s;
                if (in_valid && !ack_s) begin
                    r_d.data  = in_data;
                    r_d.last  = in_last;
                    r_d.first = 1'b1;
                    r_d.cnt   = CW'(SETUP_CYC);
                    r_d.st    = TX_SETUP;
                end
            end
            TX_SETUP: begin
                if (r_q.cnt == '0) begin
                    if (r_q.first) begin
                        r_d.req = 1'b1;
                        r_d.st  = TX_WAIT_ACK;
                    end else begin
                        r_d.stb = !r_q.stb;
                        r_d.st  = TX_WAIT_SACK;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            TX_WAIT_ACK: begin
                if (ack_s) begin
                    r_d.cnt = CW'(HOLD_CYC);
                    r_d.st  = TX_HOLD;
                end
            end
            TX_WAIT_SACK: begin
                if (sack_s == r_q.stb) begin
                    r_d.cnt = CW'(HOLD_CYC);
                    r_d.st  = TX_HOLD;
                end
            end
            TX_HOLD: begin
                if (r_q.cnt == '0) begin
                    if (r_q.last) begin
                        r_d.req = 1'b0;
                        r_d.st  = TX_WAIT_LOW;
                    end else begin
                        r_d.st  = TX_NEXT;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            TX_NEXT: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    r_d.data  = in_data;
                    r_d.last  = in_last;
                    r_d.first = 1'b0;
                    r_d.cnt   = CW'(SETUP_CYC);
                    r_d.st    = TX_SETUP;
                end
            end
            TX_WAIT_LOW: begin
                if (!ack_s) r_d.st = TX_IDLE;
            end
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= TX_IDLE;
            r_q.cnt   <= '0;
            r_q.data  <= '0;
            r_q.last  <= 1'b0;
            r_q.first <= 1'b0;
            r_q.req   <= 1'b0;
            r_q.stb   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_req  = r_q.req;
    assign bus_stb  = r_q.stb;
    assign bus_data = r_q.data;

    // Spacing monitors for the assertions below
    logic [SW-1:0] stable_q, held_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            stable_q <= '0;
            held_q   <= '0;
        end else begin
            if (r_d.data != r_q.data)  stable_q <= '0;
            else if (stable_q != '1)   stable_q <= stable_q + SW'(1);
            if (!(ack_s && r_q.req))   held_q   <= '0;
            else if (held_q != '1)     held_q   <= held_q + SW'(1);
        end
    end

    assert_req_rise_ack_low_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.req) |-> !$past(ack_s));
    assert_req_fall_ack_high_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(r_q.req) |-> $past(ack_s));
    assert_ready_needs_ack_low_R2: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !r_q.req) |-> !ack_s);
    assert_setup_before_edge_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(r_q.req) || (r_q.stb != $past(r_q.stb))) |-> ($past(stable_q) >= SW'(SETUP_CYC)));
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(r_q.req) |-> ($past(held_q) >= SW'(HOLD_CYC)));
    assert_data_held_R5: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == TX_WAIT_ACK || r_q.st == TX_WAIT_SACK || r_q.st == TX_HOLD) |=> $stable(r_q.data));
endmodule

// File: rtl/hs_rx.sv
module hs_rx
    import hs_pkg::*;
#(
    parameter int DW          = 16,
    parameter int AW          = 8,
    parameter int HOLD_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_async,
    input  logic          stb_async,
    input  logic [DW-1:0] bus_data,
    input  logic [AW-1:0] base_addr,
    output logic          bus_ack,
    output logic          bus_sack,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int CW = $clog2(HOLD_CYC + 2);
    localparam int SW = CW + 1;

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic          stb_seen;
        logic          ack;
        logic          we;
        logic [AW-1:0] wa;
        logic [DW-1:0] wd;
    } rx_reg_t;

    rx_reg_t r_d, r_q;
    logic    req_s, stb_s;

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_req (
        .clk(clk), .rst(rst), .d(req_async), .q(req_s)
    );
    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_stb (
        .clk(clk), .rst(rst), .d(stb_async), .q(stb_s)
    );

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        unique case (r_q.st)
            RX_IDLE: begin
                if (req_s) begin
                    r_d.we   = 1'b1;
                    r_d.wa   = base_addr;
                    r_d.wd   = bus_data;
                    r_d.addr = base_addr + AW'(1);
                    r_d.cnt  = CW'(HOLD_CYC);
                    r_d.st   = RX_HOLD;
                end
            end
            RX_HOLD: begin
                if (r_q.cnt == '0) begin
                    r_d.ack = 1'b1;
                    r_d.st  = RX_BURST;
                end else begin
                    r_d.cnt = r_q.cnt - CW'(1);
                end
            end
            RX_BURST: begin
                if (stb_s != r_q.stb_seen) begin
                    r_d.we       = 1'b1;
                    r_d.wa       = r_q.addr;
                    r_d.wd       = bus_data;
                    r_d.addr     = r_q.addr + AW'(1);
                    r_d.stb_seen = stb_s;
                end else if (!req_s) begin
                    r_d.ack = 1'b0;
                    r_d.st  = RX_IDLE;
                end
            end
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st       <= RX_IDLE;
            r_q.cnt      <= '0;
            r_q.addr     <= '0;
            r_q.stb_seen <= 1'b0;
            r_q.ack      <= 1'b0;
            r_q.we       <= 1'b0;
            r_q.wa       <= '0;
            r_q.wd       <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_ack  = r_q.ack;
    assign bus_sack = r_q.stb_seen;
    assign wr_en    = r_q.we;
    assign wr_addr  = r_q.wa;
    assign wr_data  = r_q.wd;

    // Monitors for the assertions below
    logic [SW-1:0] wait_q;
    logic [AW-1:0] prev_wa_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q    <= '0;
            prev_wa_q <= '0;
        end else begin
            if (!(req_s && !r_q.ack)) wait_q <= '0;
            else if (wait_q != '1)    wait_q <= wait_q + SW'(1);
            if (r_q.we) prev_wa_q <= r_q.wa;
        end
    end

    assert_ack_rise_req_high_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.ack) |-> req_s);
    assert_ack_fall_req_low_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(r_q.ack) |-> !$past(req_s));
    assert_ack_hold_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.ack) |-> ($past(wait_q) >= SW'(HOLD_CYC)));
    assert_burst_addr_step_R6: assert property (@(posedge clk) disable iff (rst)
        (r_q.we && r_q.st == RX_BURST) |-> (r_q.wa == prev_wa_q + AW'(1)));
    assert_single_write_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        r_q.we |=> !r_q.we);
endmodule

// File: rtl/hs_link.sv
module hs_link #(
    parameter int DW          = 16,
    parameter int AW          = 8,
    parameter int TX_SETUP    = 3,
    parameter int TX_HOLD     = 2,
    parameter int RX_HOLD     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk_tx,
    input  logic          rst_tx,
    input  logic          clk_rx,
    input  logic          rst_rx,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_last,
    input  logic [AW-1:0] rx_base,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          bus_req,
    output logic          bus_stb,
    output logic [DW-1:0] bus_data,
    output logic          bus_ack,
    output logic          bus_sack
);
    hs_tx #(
        .DW(DW), .SETUP_CYC(TX_SETUP), .HOLD_CYC(TX_HOLD), .SYNC_STAGES(SYNC_STAGES)
    ) u_tx (
        .clk(clk_tx), .rst(rst_tx),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .bus_req(bus_req), .bus_stb(bus_stb), .bus_data(bus_data),
        .ack_async(bus_ack), .sack_async(bus_sack)
    );

    hs_rx #(
        .DW(DW), .AW(AW), .HOLD_CYC(RX_HOLD), .SYNC_STAGES(SYNC_STAGES)
    ) u_rx (
        .clk(clk_rx), .rst(rst_rx),
        .req_async(bus_req), .stb_async(bus_stb), .bus_data(bus_data), .base_addr(rx_base),
        .bus_ack(bus_ack), .bus_sack(bus_sack),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );
endmodule

// File: tb/tb_hs_link.sv
`timescale 1ns/1ps
module tb_hs_link;
    localparam int DW = 16, AW = 8;
    localparam int TX_SETUP = 3, TX_HOLD = 2, RX_HOLD = 2, SYNC_STAGES = 2;
    localparam int QMAX = 1024;
    localparam int CYC_LIMIT = 150000;

    logic clk_tx = 0, clk_rx = 0, rst_tx = 1, rst_rx = 1;
    logic in_valid = 0, in_last = 0, in_ready;
    logic [DW-1:0] in_data = '0;
    logic [AW-1:0] rx_base = '0;
    logic wr_en, bus_req, bus_stb, bus_ack, bus_sack;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data, bus_data;

    always #2.0 clk_tx = ~clk_tx;
    always #3.5 clk_rx = ~clk_rx;

    hs_link #(.DW(DW), .AW(AW), .TX_SETUP(TX_SETUP), .TX_HOLD(TX_HOLD),
              .RX_HOLD(RX_HOLD), .SYNC_STAGES(SYNC_STAGES)) dut (
        .clk_tx(clk_tx), .rst_tx(rst_tx), .clk_rx(clk_rx), .rst_rx(rst_rx),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
        .rx_base(rx_base), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bus_req(bus_req), .bus_stb(bus_stb), .bus_data(bus_data),
        .bus_ack(bus_ack), .bus_sack(bus_sack)
    );

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;
    logic [AW-1:0] exp_addr [0:QMAX-1];
    logic [DW-1:0] exp_data [0:QMAX-1];
    int wr_ptr = 0, rd_ptr = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk_tx) begin
        cyc++;
        if (cyc > CYC_LIMIT && !done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", rd_ptr, wr_ptr);
            report();
        end
    end

    // Receive-side monitor: scoreboard, pulse width, sync depth, ack hold, ordering
    bit prev_we = 0, prev_ack_r = 0, htrack = 0;
    int hcnt = 0, req_hi = 0;
    always @(negedge clk_rx) begin
        if (!rst_rx) begin
            if (bus_req) req_hi++; else req_hi = 0;
            if (wr_en) begin
                if (rd_ptr < wr_ptr) begin
                    chk(wr_addr == exp_addr[rd_ptr], "R6 write address", wr_addr, exp_addr[rd_ptr]);
                    chk(wr_data == exp_data[rd_ptr], "R10 write data", wr_data, exp_data[rd_ptr]);
                    rd_ptr++;
                end else begin
                    chk(0, "R10 unexpected write", wr_addr, 0);
                end
                chk(!prev_we, "R7 write pulse width", prev_we, 0);
                if (!bus_ack) begin
                    chk(req_hi >= SYNC_STAGES, "R8 request sync depth", req_hi, SYNC_STAGES);
                    htrack = 1; hcnt = 0;
                end
            end else if (htrack && !bus_ack) begin
                hcnt++;
            end
            if (htrack && bus_ack) begin
                chk(hcnt >= RX_HOLD, "R4 receiver hold", hcnt, RX_HOLD);
                htrack = 0;
            end
            if (bus_ack && !prev_ack_r) chk(bus_req, "R1 ack rise with req high", bus_req, 1);
            if (!bus_ack && prev_ack_r) chk(!bus_req, "R1 ack fall with req low", bus_req, 0);
            prev_we = wr_en; prev_ack_r = bus_ack;
        end
    end

    // Transmit-side monitor: ordering, setup, sender hold, ready
    bit prev_req = 0, prev_stb = 0;
    logic [DW-1:0] prev_data = '0;
    int scnt = 0, acnt = 0;
    always @(negedge clk_tx) begin
        if (!rst_tx) begin
            if (bus_req && !prev_req) begin
                chk(!bus_ack, "R1 req rise with ack low", bus_ack, 0);
                chk(scnt >= TX_SETUP, "R3 setup before req", scnt, TX_SETUP);
            end
            if (bus_stb != prev_stb) chk(scnt >= TX_SETUP, "R3 setup before strobe", scnt, TX_SETUP);
            if (!bus_req && prev_req) begin
                chk(bus_ack, "R1 req fall with ack high", bus_ack, 1);
                chk(acnt >= TX_HOLD, "R5 sender hold", acnt, TX_HOLD);
                acnt = 0;
            end
            if (bus_req && bus_ack) acnt++;
            if (bus_data != prev_data) scnt = 0; else scnt++;
            if (in_ready && !bus_req) chk(!bus_ack, "R2 ready while ack high", bus_ack, 0);
            prev_req = bus_req; prev_stb = bus_stb; prev_data = bus_data;
        end
    end

    task automatic push(input logic [DW-1:0] d, input bit l);
        in_valid = 1; in_data = d; in_last = l;
        while (!in_ready) @(negedge clk_tx);
        @(negedge clk_tx);
        in_valid = 0; in_last = 0;
        if (l) chk(!in_ready, "R2 ready low after last", in_ready, 0);
    endtask

    task automatic send_burst(input logic [AW-1:0] base, input int n, input int mode, input int gap);
        logic [DW-1:0] d;
        @(negedge clk_tx);
        while (!in_ready) @(negedge clk_tx);
        rx_base = base;
        for (int i = 0; i < n; i++) begin
            if (mode == 1) d = (i % 2 == 0) ? '0 : '1;
            else           d = DW'($urandom);
            exp_addr[wr_ptr] = base + AW'(i);
            exp_data[wr_ptr] = d;
            wr_ptr++;
            push(d, i == n - 1);
            for (int g = 0; g < gap; g++) @(negedge clk_tx);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (6) @(negedge clk_rx);
        @(negedge clk_tx);
        chk(!bus_req && !bus_stb, "R9 req/stb in reset", {bus_req, bus_stb}, 0);
        rst_tx = 0; rst_rx = 0;
        @(negedge clk_tx);
        chk(!bus_req && !bus_stb && !bus_ack && !bus_sack, "R9 bus after reset",
            {bus_req, bus_stb, bus_ack, bus_sack}, 0);
        chk(in_ready, "R9 ready after reset", in_ready, 1);
        chk(!wr_en, "R9 no write after reset", wr_en, 0);

        // Directed corner cases
        send_burst(8'h10, 1, 0, 0);              // R10 single word
        send_burst(8'h11, 1, 1, 0);              // R2 back-to-back single words
        send_burst(8'hFE, 4, 0, 0);              // R6 wrap past top of address space
        send_burst(8'h40, 8, 1, 0);              // R3 alternating all-zero / all-one words
        send_burst(8'hFF, 2, 1, 3);              // R6 wrap with gaps between words

        // Constrained random handshakes
        for (int b = 0; b < 60; b++) begin
            send_burst(AW'($urandom), 1 + int'($urandom % 5), int'($urandom % 2), int'($urandom % 4));
        end

        while (rd_ptr != wr_ptr) @(negedge clk_tx);
        while (bus_req || bus_ack) @(negedge clk_tx);
        repeat (10) @(negedge clk_tx);
        chk(rd_ptr == wr_ptr, "R10 all words written", rd_ptr, wr_ptr);
        chk(in_ready && !bus_req && !bus_ack, "R1 link idle at end", {in_ready, bus_req, bus_ack}, 3'b100);
        report();
    end
endmodule